// File: doc/BRIEF.md
# Memory Request Burst Splitter

This block turns one memory request (start byte address, byte length, read or write) into the series of DRAM bursts that covers it. Each burst carries its own address and byte size, and a flag marks the final burst of the request. The address it works on is the controller-local offset: the dense address that starts at zero and that an earlier stage has already derived from the system address. Both the first byte and the end byte of the request are computed in that space. The burst length is a power-of-two parameter.

The first burst keeps the request's start address even when that address is not aligned. Every later burst begins on a burst boundary. Each burst stops at the next boundary or at the request end, whichever comes first. A request is taken only when the block is idle, so a new request can enter only after the last burst of the previous one has been handed downstream. Bursts wait under backpressure and keep their values. A request of length zero is rejected with a one-cycle error pulse and produces no burst.

The block counts handed-off bursts separately for reads and for writes. It also keeps a histogram of burst sizes, with one counter per ceiling-log2 bin.

Top module: `burst_splitter`

## Requirements
- R1: After reset, bst_valid and req_err are 0, req_ready is 1, and rd_count, wr_count and every size_hist bin are 0.
- R2: The first burst of a request carries the request's start address, aligned or not.
- R3: Every burst after the first starts at an address whose low log2(BURST_BYTES) bits are zero, and that address equals the previous burst's address plus its size.
- R4: Each burst's size equals min(next burst boundary above its address, start + length) minus its address. It lies in 1..BURST_BYTES, and the sizes of a request's bursts add up to its length.
- R5: A request produces exactly as many bursts as the burst-aligned regions it touches. bst_last is 1 on the final burst only.
- R6: req_ready is 0 while any burst of the current request is still to be handed off, and a request offered during that time is ignored. req_ready returns to 1 in the cycle after the last burst is handed off.
- R7: While bst_valid is 1 and bst_ready is 0, bst_valid stays 1 and bst_addr, bst_size, bst_last and bst_write stay unchanged in the next cycle.
- R8: An accepted request with req_len = 0 gives req_err = 1 for exactly the following cycle. It produces no burst and leaves all counters unchanged.
- R9: bst_write equals the request's req_write. Each handed-off burst (bst_valid and bst_ready both 1) adds one to wr_count if bst_write is 1, and to rd_count otherwise.
- R10: Each handed-off burst of size s adds one to size_hist bin ceil(log2(s)): size 1 goes to bin 0, size 2 to bin 1, sizes 3 and 4 to bin 2, and BURST_BYTES to bin log2(BURST_BYTES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block is idle and will take a request |
| req_addr | input | ADDR_W | Controller-local start byte address |
| req_len | input | LEN_W | Request length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_err | output | 1 | One-cycle pulse after a zero-length request is accepted |
| bst_valid | output | 1 | A burst is presented |
| bst_ready | input | 1 | Downstream takes the burst |
| bst_addr | output | ADDR_W | Burst start byte address |
| bst_size | output | log2(BURST_BYTES)+1 | Burst size in bytes |
| bst_write | output | 1 | Direction of the burst |
| bst_last | output | 1 | Final burst of the request |
| rd_count | output | CNT_W | Read bursts handed off |
| wr_count | output | CNT_W | Write bursts handed off |
| size_hist | output | (log2(BURST_BYTES)+1) x CNT_W | Burst-size histogram, bin i holds sizes with ceil(log2) = i |

## Verification
Some properties can be checked on every cycle. These are that later bursts start aligned and continue from the end of the previous burst, that bursts stay frozen under backpressure, that the size stays within range, that req_ready is low while bursts are pending, that a zero-length request raises the error flag, and that the read counter steps by one. Other behaviour only shows in the bench's scenarios. This covers the first burst keeping an unaligned start, the exact size of each burst including the clipped tail, the burst count per request, the placement of bst_last, requests ignored while busy, and the final histogram and counter totals.

// File: rtl/burst_split_pkg.sv
package burst_split_pkg;

  typedef enum logic [0:0] {
    SPLIT_IDLE = 1'b0,
    SPLIT_RUN  = 1'b1
  } split_state_e;

endpackage

// File: rtl/burst_step.sv
// Combinational step: next boundary, clipped size and last flag for the
// burst that starts at cur_addr.
module burst_step #(
  parameter int AW          = 33,
  parameter int BURST_BYTES = 64,
  localparam int OFS_W      = $clog2(BURST_BYTES),
  localparam int SIZE_W     = OFS_W + 1
) (
  input  logic [AW-1:0]     cur_addr,
  input  logic [AW-1:0]     end_addr,
  output logic [AW-1:0]     next_bnd,
  output logic [SIZE_W-1:0] size,
  output logic              is_last
);

  localparam logic [AW-1:0] LOW_MASK = AW'(BURST_BYTES - 1);

  logic [AW-1:0] limit;
  logic [AW-1:0] span;

  always_comb begin
    next_bnd = (cur_addr | LOW_MASK) + AW'(1);
    is_last  = (next_bnd >= end_addr);
    limit    = is_last ? end_addr : next_bnd;
    span     = limit - cur_addr;
    size     = span[SIZE_W-1:0];
  end

endmodule

// File: rtl/burst_size_binner.sv
// ceil(log2(size)) computed as the bit length of (size - 1).
module burst_size_binner #(
  parameter int SIZE_W = 7,
  parameter int BIN_W  = 3
) (
  input  logic [SIZE_W-1:0] size,
  output logic [BIN_W-1:0]  bin
);

  logic [SIZE_W-1:0] dec;

  always_comb begin
    dec = size - SIZE_W'(1);
    bin = '0;
    for (int i = 0; i < SIZE_W; i++) begin
      if (dec[i]) bin = BIN_W'(i + 1);
    end
  end

endmodule

// File: rtl/burst_stats.sv
// Per-direction burst counters and size histogram.
module burst_stats #(
  parameter int CNT_W    = 16,
  parameter int BINS     = 7,
  parameter int BIN_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  logic                       is_write,
  input  logic [BIN_W-1:0]           bin,
  output logic [CNT_W-1:0]           rd_count,
  output logic [CNT_W-1:0]           wr_count,
  output logic [BINS-1:0][CNT_W-1:0] hist
);

  logic rd_en, wr_en;

  always_comb begin
    rd_en = fire && !is_write;
    wr_en = fire &&  is_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_count <= '0;
    end else if (rd_en) begin
      rd_count <= rd_count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_count <= '0;
    end else if (wr_en) begin
      wr_count <= wr_count + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < BINS; g++) begin : g_bin
    logic bin_en;
    always_comb bin_en = fire && (bin == BIN_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist[g] <= '0;
      end else if (bin_en) begin
        hist[g] <= hist[g] + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 64,
  parameter int CNT_W       = 16,
  localparam int OFS_W      = $clog2(BURST_BYTES),
  localparam int SIZE_W     = OFS_W + 1,
  localparam int BINS       = OFS_W + 1,
  localparam int BIN_W      = $clog2(BINS + 1),
  localparam int AW         = ADDR_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [LEN_W-1:0]           req_len,
  input  logic                       req_write,
  output logic                       req_err,
  output logic                       bst_valid,
  input  logic                       bst_ready,
  output logic [ADDR_W-1:0]          bst_addr,
  output logic [SIZE_W-1:0]          bst_size,
  output logic                       bst_write,
  output logic                       bst_last,
  output logic [CNT_W-1:0]           rd_count,
  output logic [CNT_W-1:0]           wr_count,
  output logic [BINS-1:0][CNT_W-1:0] size_hist
);
  import burst_split_pkg::*;

  split_state_e  state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] end_q, end_d;
  logic          wr_q, wr_d;
  logic          err_q, err_d;
  logic          load_en, step_en;

  logic [AW-1:0]     next_bnd;
  logic [SIZE_W-1:0] step_size;
  logic              step_last;
  logic [BIN_W-1:0]  size_bin;
  logic              accept, fire;

  burst_step #(.AW(AW), .BURST_BYTES(BURST_BYTES)) u_step (
    .cur_addr (cur_q),
    .end_addr (end_q),
    .next_bnd (next_bnd),
    .size     (step_size),
    .is_last  (step_last)
  );

  burst_size_binner #(.SIZE_W(SIZE_W), .BIN_W(BIN_W)) u_bin (
    .size (step_size),
    .bin  (size_bin)
  );

  burst_stats #(.CNT_W(CNT_W), .BINS(BINS), .BIN_W(BIN_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .is_write (wr_q),
    .bin      (size_bin),
    .rd_count (rd_count),
    .wr_count (wr_count),
    .hist     (size_hist)
  );

  always_comb begin
    req_ready = (state_q == SPLIT_IDLE);
    bst_valid = (state_q == SPLIT_RUN);
    bst_addr  = cur_q[ADDR_W-1:0];
    bst_size  = step_size;
    bst_write = wr_q;
    bst_last  = step_last;
    req_err   = err_q;
    accept    = req_valid && req_ready;
    fire      = bst_valid && bst_ready;
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    end_d   = end_q;
    wr_d    = wr_q;
    err_d   = 1'b0;
    load_en = 1'b0;
    step_en = 1'b0;
    if (accept) begin
      if (req_len == '0) begin
        err_d = 1'b1;
      end else begin
        load_en = 1'b1;
        state_d = SPLIT_RUN;
        cur_d   = {1'b0, req_addr};
        end_d   = {1'b0, req_addr} + AW'(req_len);
        wr_d    = req_write;
      end
    end else if (fire) begin
      step_en = 1'b1;
      if (step_last) begin
        state_d = SPLIT_IDLE;
      end else begin
        cur_d = next_bnd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SPLIT_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      end_q <= '0;
      wr_q  <= 1'b0;
    end else if (load_en || step_en) begin
      cur_q <= cur_d;
      end_q <= end_d;
      wr_q  <= wr_d;
    end
  end

endmodule

// File: rtl/burst_splitter_chk.sv
module burst_splitter_chk #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 64,
  parameter int CNT_W       = 16,
  localparam int OFS_W      = $clog2(BURST_BYTES),
  localparam int SIZE_W     = OFS_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_err,
  input logic              bst_valid,
  input logic              bst_ready,
  input logic [ADDR_W-1:0] bst_addr,
  input logic [SIZE_W-1:0] bst_size,
  input logic              bst_write,
  input logic              bst_last,
  input logic [CNT_W-1:0]  rd_count
);

  assert_aligned_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && bst_ready && !bst_last) |=>
      (bst_valid && bst_addr[OFS_W-1:0] == '0 &&
       bst_addr == $past(bst_addr) + ADDR_W'($past(bst_size))));

  assert_size_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_size != '0 && bst_size <= SIZE_W'(BURST_BYTES)));

  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> !req_ready);

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && !bst_ready) |=>
      (bst_valid && $stable(bst_addr) && $stable(bst_size) &&
       $stable(bst_last) && $stable(bst_write)));

  assert_zero_len_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (req_err && !bst_valid));

  assert_rd_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && bst_ready && !bst_write) |=> (rd_count == $past(rd_count) + CNT_W'(1)));

endmodule

bind burst_splitter burst_splitter_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .req_err(req_err), .bst_valid(bst_valid),
  .bst_ready(bst_ready), .bst_addr(bst_addr), .bst_size(bst_size),
  .bst_write(bst_write), .bst_last(bst_last), .rd_count(rd_count)
);

// File: tb/burst_splitter_test.sv
module burst_splitter_test;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int BB     = 64;
  localparam int CNT_W  = 16;
  localparam int OFS_W  = $clog2(BB);
  localparam int SIZE_W = OFS_W + 1;
  localparam int BINS   = OFS_W + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, req_err;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic bst_valid, bst_ready, bst_write, bst_last;
  logic [ADDR_W-1:0] bst_addr;
  logic [SIZE_W-1:0] bst_size;
  logic [CNT_W-1:0]  rd_count, wr_count;
  logic [BINS-1:0][CNT_W-1:0] size_hist;

  int checks = 0;
  int errors = 0;
  int exp_rd = 0;
  int exp_wr = 0;
  int exp_hist [BINS];
  int tick = 0;

  always #4 clk = ~clk;

  burst_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_BYTES(BB), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write), .req_err(req_err),
    .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_addr(bst_addr),
    .bst_size(bst_size), .bst_write(bst_write), .bst_last(bst_last),
    .rd_count(rd_count), .wr_count(wr_count), .size_hist(size_hist)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        wr;
    logic [7:0]  nb;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h100, 16'd64,  1'b0, 8'd1},
    '{32'h105, 16'd10,  1'b1, 8'd1},
    '{32'h13C, 16'd8,   1'b0, 8'd2},
    '{32'h201, 16'd200, 1'b1, 8'd4},
    '{32'h3C0, 16'd128, 1'b0, 8'd2},
    '{32'h07F, 16'd1,   1'b1, 8'd1},
    '{32'h041, 16'd127, 1'b0, 8'd2}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int clog2_size(input int s);
    int b = 0;
    while ((1 << b) < s) b++;
    return b;
  endfunction

  task automatic send(input logic [31:0] a, input logic [15:0] l, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_write = w;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // Collect bursts of one request with a periodic stall pattern and
  // compare against the model derived from the requirements.
  task automatic collect(input logic [31:0] a, input logic [15:0] l, input logic w,
                         input int exp_n);
    longint cur = a;
    longint fin = longint'(a) + longint'(l);
    int n = 0;
    bit stalled = 0;
    bit done = 0;
    logic [ADDR_W-1:0] s_addr;
    logic [SIZE_W-1:0] s_size;
    logic s_last, s_wr;
    for (int k = 0; k < 200 && !done; k++) begin
      @(negedge clk);
      bst_ready = ((k % 3) != 1);
      #1;
      if (stalled) begin
        check("R7 valid held", longint'(bst_valid), 1);
        check("R7 addr held", longint'(bst_addr), longint'(s_addr));
        check("R7 size held", longint'(bst_size), longint'(s_size));
        check("R7 last/write held", longint'({bst_last, bst_write}), longint'({s_last, s_wr}));
      end
      stalled = 0;
      if (bst_valid) begin
        check("R6 busy not ready", longint'(req_ready), 0);
        if (!bst_ready) begin
          stalled = 1;
          s_addr = bst_addr; s_size = bst_size; s_last = bst_last; s_wr = bst_write;
        end else begin
          longint bnd = (cur / BB + 1) * BB;
          longint lim = (bnd < fin) ? bnd : fin;
          int sz = int'(lim - cur);
          if (n == 0) check("R2 first addr", longint'(bst_addr), cur);
          else        check("R3 aligned addr", longint'(bst_addr), cur);
          check("R4 size", longint'(bst_size), longint'(sz));
          check("R5 last flag", longint'(bst_last), longint'(lim == fin));
          check("R9 direction", longint'(bst_write), longint'(w));
          if (w) exp_wr++; else exp_rd++;
          exp_hist[clog2_size(sz)]++;
          n++;
          cur = lim;
          if (lim == fin) done = 1;
        end
      end
    end
    check("R5 burst count", longint'(n), longint'(exp_n));
    @(negedge clk);
    #1;
    check("R6 ready after last", longint'(req_ready), 1);
    check("R5 no extra burst", longint'(bst_valid), 0);
  endtask

  task automatic check_stats(input string when);
    check({"R9 rd_count ", when}, longint'(rd_count), longint'(exp_rd));
    check({"R9 wr_count ", when}, longint'(wr_count), longint'(exp_wr));
    for (int i = 0; i < BINS; i++)
      check({"R10 hist bin ", when}, longint'(size_hist[i]), longint'(exp_hist[i]));
  endtask

  initial begin
    while (tick < 100000) begin
      @(posedge clk);
      tick++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < BINS; i++) exp_hist[i] = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_write = 1'b0;
    bst_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1 bst_valid", longint'(bst_valid), 0);
    check("R1 req_ready", longint'(req_ready), 1);
    check("R1 req_err", longint'(req_err), 0);
    check_stats("reset R1");
    @(negedge clk);
    rst_n = 1'b1;

    // Table-driven requests
    for (int v = 0; v < NV; v++) begin
      send(VECS[v].addr, VECS[v].len, VECS[v].wr);
      collect(VECS[v].addr, VECS[v].len, VECS[v].wr, int'(VECS[v].nb));
    end
    check_stats("after table");

    // R8: zero-length request rejected
    send(32'h180, 16'd0, 1'b1);
    check("R8 err pulse", longint'(req_err), 1);
    check("R8 no burst", longint'(bst_valid), 0);
    @(posedge clk); #1;
    check("R8 err one cycle", longint'(req_err), 0);
    check("R8 no burst later", longint'(bst_valid), 0);
    check_stats("zero len R8");

    // R6: request offered while busy is ignored
    bst_ready = 1'b0;
    send(32'h4F0, 16'd40, 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h900; req_len = 16'd4; req_write = 1'b0;
    #1;
    check("R6 ready low while busy", longint'(req_ready), 0);
    repeat (3) @(negedge clk);
    check("R6 first burst unchanged", longint'(bst_addr), 32'h4F0);
    req_valid = 1'b0;
    collect(32'h4F0, 16'd40, 1'b1, 2);
    check_stats("busy R6");

    // Boundary: full-length aligned request spanning many bursts
    send(32'h1000, 16'd512, 1'b0);
    collect(32'h1000, 16'd512, 1'b0, 8);
    check_stats("final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule